// File: doc/BRIEF.md
# Integer ALU with Shifter

This is the combinational integer execution unit of a 32-bit load-store core. In a single evaluation it takes the register value read for the first source, the register value read for the second source, a 16-bit immediate field, a 5-bit shift-amount field and a 4-bit operation code. It returns a 32-bit result and a flag that is high when that result is all zeros. Branch logic can use the flag directly for equality tests, for example after a subtract.

An internal operand-prepare step chooses the second operand. It is the second register value when `use_imm_i` is low and the extended immediate when it is high. Arithmetic and compare operations sign-extend the immediate. The logical operations zero-extend it.

Shifts always act on the second register value. The distance comes from the shift-amount field for the fixed-distance forms and from the low five bits of the first register value for the variable forms. Load-upper-immediate builds its result from the immediate alone.

Top module: `int_alu`

## Requirements
- R1: With op 0 (add) the result is the first operand plus the second operand, modulo 2^32. With op 1 (subtract) the result is the first operand minus the second operand, modulo 2^32. When `use_imm_i` is 1, the second operand is the immediate sign-extended to 32 bits.
- R2: Ops 2, 3, 4 and 5 give bitwise AND, OR, XOR and NOR of the two operands. When `use_imm_i` is 1, the second operand is the immediate zero-extended to 32 bits.
- R3: Op 6 gives 1 when the first operand is less than the second operand as two's-complement numbers, and 0 otherwise. The immediate is sign-extended.
- R4: Op 7 gives 1 when the first operand is less than the second operand as unsigned numbers, and 0 otherwise. The immediate is first sign-extended and then compared as unsigned.
- R5: Ops 8, 9 and 10 shift `b_i` left, logically right (zero fill) or arithmetically right (sign-bit fill) by `shamt_i`. `a_i` and `use_imm_i` have no effect on these ops.
- R6: Ops 11, 12 and 13 are the left, logical-right and arithmetic-right shifts of `b_i` by `a_i[4:0]`. Bits 31:5 of `a_i` have no effect.
- R7: Op 14 returns `{imm_i, 16'h0000}` regardless of `a_i` and `b_i`.
- R8: `zero_o` is 1 exactly when the 32-bit result is zero.
- R9: Op 15 is unused and returns 0.
- R10: The immediate 0x8000 sign-extends to 0xFFFF8000 for arithmetic ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First source register value |
| b_i | input | 32 | Second source register value; also the value that shifts act on |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Fixed shift distance |
| use_imm_i | input | 1 | Selects the extended immediate as the second operand |
| op_i | input | 4 | Operation code, encoded as listed in the requirements |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when the result is zero |

## Verification
The unit holds no state, so any fault shows at the ports in the same evaluation in which its inputs are applied. A wrong choice of extension shows up only when immediate bit 15 is set, so the vectors set that bit for both the arithmetic and the logical forms. A wrong fill in the right shifts shows up only when the sign bit is set. A shift distance taken from the wrong field shows up only when `a_i` and `shamt_i` differ, and the upper bits of `a_i` are loaded with ones so that any leak from them changes the result.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int DW = 32,
  parameter int IW = 16,
  parameter int SW = 5
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [IW-1:0] imm_i,
  input  logic [SW-1:0] shamt_i,
  input  logic          use_imm_i,
  input  logic [3:0]    op_i,
  output logic [DW-1:0] result_o,
  output logic          zero_o
);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_XOR  = 4'd4;
  localparam logic [3:0] OP_NOR  = 4'd5;
  localparam logic [3:0] OP_SLT  = 4'd6;
  localparam logic [3:0] OP_SLTU = 4'd7;
  localparam logic [3:0] OP_SLL  = 4'd8;
  localparam logic [3:0] OP_SRL  = 4'd9;
  localparam logic [3:0] OP_SRA  = 4'd10;
  localparam logic [3:0] OP_SLLV = 4'd11;
  localparam logic [3:0] OP_SRLV = 4'd12;
  localparam logic [3:0] OP_SRAV = 4'd13;
  localparam logic [3:0] OP_LUI  = 4'd14;
  localparam int         PADW    = DW - IW;

  logic [DW-1:0] imm_sx, imm_zx, opb_ar, opb_lg, sum, diff;
  logic [SW-1:0] var_amt;
  logic          lt_s, lt_u;

  assign imm_sx  = {{PADW{imm_i[IW-1]}}, imm_i};
  assign imm_zx  = {{PADW{1'b0}}, imm_i};
  assign opb_ar  = use_imm_i ? imm_sx : b_i;
  assign opb_lg  = use_imm_i ? imm_zx : b_i;
  assign sum     = a_i + opb_ar;
  assign diff    = a_i - opb_ar;
  assign lt_s    = $signed(a_i) < $signed(opb_ar);
  assign lt_u    = a_i < opb_ar;
  assign var_amt = a_i[SW-1:0];

  always_comb begin
    unique case (op_i)
      OP_ADD:  result_o = sum;
      OP_SUB:  result_o = diff;
      OP_AND:  result_o = a_i & opb_lg;
      OP_OR:   result_o = a_i | opb_lg;
      OP_XOR:  result_o = a_i ^ opb_lg;
      OP_NOR:  result_o = ~(a_i | opb_lg);
      OP_SLT:  result_o = {{(DW-1){1'b0}}, lt_s};
      OP_SLTU: result_o = {{(DW-1){1'b0}}, lt_u};
      OP_SLL:  result_o = b_i << shamt_i;
      OP_SRL:  result_o = b_i >> shamt_i;
      OP_SRA:  result_o = DW'($signed(b_i) >>> shamt_i);
      OP_SLLV: result_o = b_i << var_amt;
      OP_SRLV: result_o = b_i >> var_amt;
      OP_SRAV: result_o = DW'($signed(b_i) >>> var_amt);
      OP_LUI:  result_o = {imm_i, {PADW{1'b0}}};
      default: result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk (
  input logic [31:0] a_i,
  input logic [31:0] b_i,
  input logic [15:0] imm_i,
  input logic [4:0]  shamt_i,
  input logic        use_imm_i,
  input logic [3:0]  op_i,
  input logic [31:0] result_o,
  input logic        zero_o
);
  always_comb begin
    if (op_i == 4'd1 && !use_imm_i) begin
      a_r1_sub_inverse: assert (32'(result_o + b_i) == a_i)
        else $error("R1 subtract result does not add back to a");
    end
    if (op_i == 4'd6 || op_i == 4'd7) begin
      a_r3_slt_binary: assert (result_o[31:1] == 31'd0)
        else $error("R3/R4 compare result wider than one bit");
    end
    if (op_i == 4'd9 && shamt_i != 5'd0) begin
      a_r5_srl_zero_fill: assert (result_o[31] == 1'b0)
        else $error("R5 logical right shift filled with one");
    end
    if (op_i == 4'd14) begin
      a_r7_lui_layout: assert (result_o == {imm_i, 16'h0000})
        else $error("R7 load-upper layout wrong");
    end
    if (op_i == 4'd15) begin
      a_r9_unused_zero: assert (result_o == 32'd0 && zero_o)
        else $error("R9 unused op gave nonzero");
    end
    if (zero_o) begin
      a_r8_zero_flag: assert (result_o == 32'd0)
        else $error("R8 zero flag with nonzero result");
    end
  end
endmodule

bind int_alu int_alu_chk u_chk (
  .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .shamt_i(shamt_i),
  .use_imm_i(use_imm_i), .op_i(op_i), .result_o(result_o), .zero_o(zero_o)
);

// File: tb/int_alu_tb.sv
module int_alu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a, b, res;
  logic [15:0] imm;
  logic [4:0]  sh;
  logic        ui, zf;
  logic [3:0]  op;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  int_alu u_dut (
    .a_i(a), .b_i(b), .imm_i(imm), .shamt_i(sh), .use_imm_i(ui),
    .op_i(op), .result_o(res), .zero_o(zf)
  );

  // tag[125:122] op[121:118] ui[117] a[116:85] b[84:53] imm[52:37] sh[36:32] exp[31:0]
  localparam int NV = 27;
  localparam logic [125:0] VEC [NV] = '{
    {4'd1,  4'd0,  1'b0, 32'h7FFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h80000000}, // R1
    {4'd1,  4'd0,  1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000000}, // R1
    {4'd10, 4'd0,  1'b1, 32'h00000010, 32'h12345678, 16'h8000, 5'd0,  32'hFFFF8010}, // R10
    {4'd1,  4'd1,  1'b0, 32'h00000005, 32'h00000007, 16'h0000, 5'd0,  32'hFFFFFFFE}, // R1
    {4'd1,  4'd1,  1'b1, 32'h00000000, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000001}, // R1
    {4'd2,  4'd2,  1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h8001, 5'd0,  32'h00008001}, // R2
    {4'd2,  4'd3,  1'b0, 32'hF0F00000, 32'h0000F0F0, 16'h0000, 5'd0,  32'hF0F0F0F0}, // R2
    {4'd2,  4'd4,  1'b0, 32'hAAAAAAAA, 32'hFFFF0000, 16'h0000, 5'd0,  32'h5555AAAA}, // R2
    {4'd2,  4'd5,  1'b0, 32'h0F0F0F0F, 32'hF0F00000, 16'h0000, 5'd0,  32'h0000F0F0}, // R2
    {4'd2,  4'd5,  1'b1, 32'h00000000, 32'hFFFFFFFF, 16'h8000, 5'd0,  32'hFFFF7FFF}, // R2
    {4'd3,  4'd6,  1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000001}, // R3
    {4'd3,  4'd6,  1'b0, 32'h00000005, 32'h00000005, 16'h0000, 5'd0,  32'h00000000}, // R3
    {4'd3,  4'd6,  1'b1, 32'h00000000, 32'h00000000, 16'h8000, 5'd0,  32'h00000000}, // R3
    {4'd4,  4'd7,  1'b0, 32'hFFFFFFFF, 32'h00000001, 16'h0000, 5'd0,  32'h00000000}, // R4
    {4'd4,  4'd7,  1'b1, 32'h00001000, 32'h00000000, 16'hFFFF, 5'd0,  32'h00000001}, // R4
    {4'd5,  4'd8,  1'b0, 32'hFFFFFFFF, 32'h8000000F, 16'h0000, 5'd4,  32'h000000F0}, // R5
    {4'd5,  4'd9,  1'b1, 32'h0000001F, 32'h80000000, 16'hFFFF, 5'd31, 32'h00000001}, // R5
    {4'd5,  4'd10, 1'b0, 32'h00000000, 32'h80000000, 16'h0000, 5'd4,  32'hF8000000}, // R5
    {4'd5,  4'd10, 1'b0, 32'h00000003, 32'h12345678, 16'h0000, 5'd0,  32'h12345678}, // R5
    {4'd6,  4'd11, 1'b0, 32'hFFFFFFE3, 32'h00000001, 16'h0000, 5'd9,  32'h00000008}, // R6
    {4'd6,  4'd12, 1'b0, 32'hFFFFFFE4, 32'hF0000000, 16'h0000, 5'd1,  32'h0F000000}, // R6
    {4'd6,  4'd13, 1'b0, 32'h0000001F, 32'h80000000, 16'h0000, 5'd0,  32'hFFFFFFFF}, // R6
    {4'd6,  4'd13, 1'b0, 32'hFFFFFFE0, 32'h80000000, 16'h0000, 5'd7,  32'h80000000}, // R6
    {4'd7,  4'd14, 1'b0, 32'h11111111, 32'h22222222, 16'h8001, 5'd3,  32'h80010000}, // R7
    {4'd7,  4'd14, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h0000, 5'd3,  32'h00000000}, // R7
    {4'd9,  4'd15, 1'b0, 32'h00000001, 32'h00000002, 16'h1234, 5'd5,  32'h00000000}, // R9
    {4'd9,  4'd15, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 5'd31, 32'h00000000}  // R9
  };

  task automatic apply(input logic [3:0] o, input logic u, input logic [31:0] va,
                       input logic [31:0] vb, input logic [15:0] vi, input logic [4:0] vs);
    @(posedge clk);
    op = o; ui = u; a = va; b = vb; imm = vi; sh = vs;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (res !== exp) begin
      fails++;
      $display("FAIL %s result: actual %h expected %h (op %0d)", req, res, exp, op);
    end
    checks++;
    if (zf !== (exp == 32'd0)) begin
      fails++;
      $display("FAIL R8 zero flag: actual %b expected %b (op %0d)", zf, (exp == 32'd0), op);
    end
  endtask

  initial begin
    op = '0; ui = 1'b0; a = '0; b = '0; imm = '0; sh = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle add", 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [125:0] v;
      v = VEC[i];
      apply(v[121:118], v[117], v[116:85], v[84:53], v[52:37], v[36:32]);
      check($sformatf("R%0d vec%0d", v[125:122], i), v[31:0]);
    end

    // R5: arithmetic right shift fill at every distance
    for (int s = 0; s < 32; s++) begin
      apply(4'd10, 1'b0, 32'hFFFFFFFF, 32'h80000000, 16'h0, s[4:0]);
      check("R5 sra sweep", ~(32'hFFFFFFFF >> (s + 1)));
    end
    // R6: variable shift distance taken only from a[4:0]
    for (int s = 0; s < 32; s++) begin
      apply(4'd12, 1'b0, {27'h5A5A5A5, s[4:0]}, 32'h80000000, 16'h0, 5'd31 - s[4:0]);
      check("R6 srlv sweep", 32'h80000000 >> s);
    end
    // R2: NOR of all zeros is all ones
    apply(4'd5, 1'b0, 32'h0, 32'h0, 16'h0, 5'd0);
    check("R2 nor zero", 32'hFFFFFFFF);
    // R3 vs R4: the same operands order differently as signed and unsigned
    apply(4'd6, 1'b0, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0);
    check("R3 most negative", 32'd1);
    apply(4'd7, 1'b0, 32'h80000000, 32'h7FFFFFFF, 16'h0, 5'd0);
    check("R4 most negative unsigned", 32'd0);
    // R10: the immediate with bit 15 clear is not extended with ones
    apply(4'd0, 1'b1, 32'h0, 32'hFFFFFFFF, 16'h7FFF, 5'd0);
    check("R10 positive imm", 32'h00007FFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule